// File: doc/BRIEF.md
# Oversampled Asynchronous-Character Word Codec

This block lets a word-oriented synchronous serial port carry asynchronous characters with one start bit, eight data bits, no parity and one stop bit. Each asynchronous bit time is carried as one 16-bit word. The port samples the line sixteen times per bit, so a clean bit arrives as a word of all ones or all zeros.

On the transmit side, the block takes a byte and produces ten words on consecutive clock cycles: a zero word, eight data words sent least significant bit first, and an all-ones word. On the receive side, it waits on the incoming word stream for a word that decodes as zero. It then collects the next nine words, rebuilds the byte from the eight data words, and reports the byte together with a flag that marks a bad stop word. Each received word is classed by a majority vote over its sixteen samples, which tolerates a few samples taken across a bit edge.

A free-running divider makes the sample-rate tick for the serial port. Its period is set by the system clock and baud rate parameters, at sixteen ticks per bit.

Top module: `uart_word_codec`

## Requirements
- R1: After a byte is accepted (tx_valid and tx_ready high at a rising edge), tx_word_valid is high for exactly the next ten cycles. tx_word carries, in order: 0000h, then one word per data bit starting with bit 0 (FFFFh for a 1, 0000h for a 0), then FFFFh.
- R2: tx_ready is low during every cycle in which a frame word is presented, and high otherwise. A tx_valid seen while tx_ready is low is ignored and never produces a frame.
- R3: A received word decodes as 1 only when more than eight of its sixteen bits are 1. A word with exactly eight ones decodes as 0.
- R4: While no frame is in progress, valid words that decode as 1 are discarded. The first valid word that decodes as 0 is taken as the start word.
- R5: Received words 2 to 9 of a frame form the byte, least significant bit first. rx_byte and rx_byte_valid appear on the cycle after the tenth word is taken, and rx_byte_valid is a single-cycle pulse.
- R6: rx_frame_err is high alongside rx_byte_valid when the tenth word decodes as 0, and low when it decodes as 1.
- R7: sample_tick is a one-cycle pulse every CLK_HZ/(16*BAUD) cycles, which is 162 cycles at the default 100 MHz and 38400 baud. This matches a divider setting of that quotient minus one (161).
- R8: During and right after reset, tx_ready is 1 and tx_word_valid, rx_byte_valid and sample_tick are 0.
- R9: Cycles with rx_word_valid low are ignored, including between words of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_byte | input | 8 | Byte to send |
| tx_valid | input | 1 | tx_byte is offered |
| tx_ready | output | 1 | Transmitter idle, byte can be taken |
| tx_word | output | 16 | Outgoing oversampled bit word |
| tx_word_valid | output | 1 | tx_word is a frame word |
| rx_word | input | 16 | Incoming oversampled bit word |
| rx_word_valid | input | 1 | rx_word is valid this cycle |
| rx_byte | output | 8 | Rebuilt byte |
| rx_byte_valid | output | 1 | One-cycle pulse: rx_byte and rx_frame_err are valid |
| rx_frame_err | output | 1 | Stop word decoded as 0 |
| sample_tick | output | 1 | Sample-rate clock enable, sixteen per bit |

## Verification
All 256 byte values are sent through the transmitter, and the captured ten-word frames are fed back into the receiver. This separates bit order, start and stop placement, and byte reconstruction. Some of these frames have idle gaps between words, and some have a second byte offered during the frame, to show that gaps and busy-time offers have no effect. A noise sweep clears or sets 0 to 8 samples per word. This locates the majority threshold exactly at the eight-ones tie. Frames with all-ones idle words in front, and stop words of zero, eight ones and nine ones, tell hunting and stop checking apart. The spacing of sample_tick pulses is measured against the divider formula.

// File: rtl/uart_word_pkg.sv
package uart_word_pkg;

    localparam int WORD_W      = 16;
    localparam int DATA_BITS   = 8;
    localparam int FRAME_WORDS = DATA_BITS + 2;
    localparam int IDX_W       = $clog2(FRAME_WORDS);

    typedef logic [WORD_W-1:0]    word_t;
    typedef logic [DATA_BITS-1:0] byte_t;

    typedef enum logic {
        RX_HUNT  = 1'b0,
        RX_FRAME = 1'b1
    } rx_state_e;

    typedef struct packed {
        logic                   busy;
        logic [IDX_W-1:0]       idx;
        logic [FRAME_WORDS-1:0] bits;
    } tx_state_t;

    typedef struct packed {
        rx_state_e        state;
        logic [IDX_W-1:0] idx;
        byte_t            shreg;
    } rx_state_t;

    // Replicate one asynchronous bit across a whole sample word.
    function automatic word_t expand_bit(input logic b);
        return {WORD_W{b}};
    endfunction

    // Majority decision: strictly more than half the samples high.
    function automatic logic vote_word(input word_t w);
        int ones;
        ones = 0;
        for (int i = 0; i < WORD_W; i++) begin
            ones += int'(w[i]);
        end
        return (ones > WORD_W / 2);
    endfunction

    // Divider terminal value for WORD_W samples per bit.
    function automatic int div_value(input int clk_hz, input int baud);
        return clk_hz / (WORD_W * baud) - 1;
    endfunction

endpackage

// File: rtl/uart_word_baud_div.sv
module uart_word_baud_div
    import uart_word_pkg::*;
#(
    parameter int CLK_HZ = 100_000_000,
    parameter int BAUD   = 38400
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int DIV = div_value(CLK_HZ, BAUD);
    localparam int CW  = (DIV > 0) ? $clog2(DIV + 1) : 1;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt == CW'(DIV)) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end

    // R7
    div_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(DIV));

    generate
        if (DIV > 0) begin : g_pulse
            // R7
            tick_pulse_chk: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/uart_word_tx.sv
module uart_word_tx
    import uart_word_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  byte_t in_byte,
    input  logic  in_valid,
    output logic  in_ready,
    output word_t out_word,
    output logic  out_valid
);
    tx_state_t st;

    assign in_ready  = !st.busy;
    assign out_valid = st.busy;
    assign out_word  = expand_bit(st.bits[0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else if (st.busy) begin
            if (st.idx == IDX_W'(FRAME_WORDS - 1)) begin
                st.busy <= 1'b0;
            end else begin
                st.idx  <= st.idx + 1'b1;
                st.bits <= st.bits >> 1;
            end
        end else if (in_valid) begin
            st.busy <= 1'b1;
            st.idx  <= '0;
            st.bits <= {1'b1, in_byte, 1'b0};
        end
    end

    // R1
    tx_start_word_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> (out_valid && out_word == '0));

    // R1
    tx_stop_word_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(out_valid) |-> ($past(out_word) == '1));

    // R2
    tx_ready_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(in_ready) |-> $past(out_valid));

endmodule

// File: rtl/uart_word_rx.sv
module uart_word_rx
    import uart_word_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  word_t in_word,
    input  logic  in_valid,
    output byte_t out_byte,
    output logic  out_valid,
    output logic  out_err
);
    rx_state_t st;
    logic      bit_now;

    assign bit_now = vote_word(in_word);

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= '{state: RX_HUNT, idx: '0, shreg: '0};
            out_byte  <= '0;
            out_valid <= 1'b0;
            out_err   <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            if (in_valid) begin
                case (st.state)
                    RX_HUNT: begin
                        if (!bit_now) begin
                            st.state <= RX_FRAME;
                            st.idx   <= IDX_W'(1);
                        end
                    end
                    RX_FRAME: begin
                        if (st.idx == IDX_W'(FRAME_WORDS - 1)) begin
                            out_byte  <= st.shreg;
                            out_err   <= !bit_now;
                            out_valid <= 1'b1;
                            st.state  <= RX_HUNT;
                            st.idx    <= '0;
                        end else begin
                            st.shreg <= {bit_now, st.shreg[DATA_BITS-1:1]};
                            st.idx   <= st.idx + 1'b1;
                        end
                    end
                    default: st.state <= RX_HUNT;
                endcase
            end
        end
    end

    // R5
    rx_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    // R4
    rx_hunt_chk: assert property (@(posedge clk) disable iff (rst)
        (st.state == RX_HUNT && in_valid && bit_now) |=> (st.state == RX_HUNT && !out_valid));

    // R9
    rx_gap_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(st.shreg) && $stable(st.idx) && !out_valid));

endmodule

// File: rtl/uart_word_codec.sv
module uart_word_codec
    import uart_word_pkg::*;
#(
    parameter int CLK_HZ = 100_000_000,
    parameter int BAUD   = 38400
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [7:0]  tx_byte,
    input  logic        tx_valid,
    output logic        tx_ready,
    output logic [15:0] tx_word,
    output logic        tx_word_valid,
    input  logic [15:0] rx_word,
    input  logic        rx_word_valid,
    output logic [7:0]  rx_byte,
    output logic        rx_byte_valid,
    output logic        rx_frame_err,
    output logic        sample_tick
);
    uart_word_tx u_tx (
        .clk       (clk),
        .rst       (rst),
        .in_byte   (tx_byte),
        .in_valid  (tx_valid),
        .in_ready  (tx_ready),
        .out_word  (tx_word),
        .out_valid (tx_word_valid)
    );

    uart_word_rx u_rx (
        .clk       (clk),
        .rst       (rst),
        .in_word   (rx_word),
        .in_valid  (rx_word_valid),
        .out_byte  (rx_byte),
        .out_valid (rx_byte_valid),
        .out_err   (rx_frame_err)
    );

    uart_word_baud_div #(
        .CLK_HZ (CLK_HZ),
        .BAUD   (BAUD)
    ) u_div (
        .clk  (clk),
        .rst  (rst),
        .tick (sample_tick)
    );

endmodule

// File: tb/tb_uart_word_codec.sv
`timescale 1ns/1ps
module tb_uart_word_codec;

    localparam int CLK_HZ   = 100_000_000;
    localparam int BAUD     = 38400;
    localparam int TICK_PER = CLK_HZ / (16 * BAUD);

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  tx_byte = '0;
    logic        tx_valid = 1'b0;
    logic        tx_ready;
    logic [15:0] tx_word;
    logic        tx_word_valid;
    logic [15:0] rx_word = '1;
    logic        rx_word_valid = 1'b0;
    logic [7:0]  rx_byte;
    logic        rx_byte_valid;
    logic        rx_frame_err;
    logic        sample_tick;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [15:0] cap [10];
    logic [15:0] frm [10];

    always #2.5 clk = ~clk;

    uart_word_codec #(.CLK_HZ(CLK_HZ), .BAUD(BAUD)) dut (
        .clk(clk), .rst(rst),
        .tx_byte(tx_byte), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_word(tx_word), .tx_word_valid(tx_word_valid),
        .rx_word(rx_word), .rx_word_valid(rx_word_valid),
        .rx_byte(rx_byte), .rx_byte_valid(rx_byte_valid),
        .rx_frame_err(rx_frame_err), .sample_tick(sample_tick)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Send a byte; optionally offer another byte while busy (must be ignored).
    task automatic tx_frame(input logic [7:0] b, input bit poke);
        logic [15:0] exp;
        @(negedge clk);
        tx_byte  = b;
        tx_valid = 1'b1;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (i == 0) begin
                tx_valid = poke;
                tx_byte  = ~b;
            end
            if (i == 8) tx_valid = 1'b0;
            exp = (i == 0) ? 16'h0000 : (i == 9) ? 16'hFFFF : {16{b[i-1]}};
            cap[i] = tx_word;
            chk(tx_word_valid === 1'b1, "R1", "word_valid", tx_word_valid, 1);
            chk(tx_word === exp, "R1", "frame word", tx_word, exp);
            chk(tx_ready === 1'b0, "R2", "ready while busy", tx_ready, 0);
        end
        @(negedge clk);
        chk(tx_word_valid === 1'b0, "R1", "valid after ten words", tx_word_valid, 0);
        chk(tx_ready === 1'b1, "R2", "ready after frame", tx_ready, 1);
        @(negedge clk);
        chk(tx_word_valid === 1'b0, "R2", "busy offer ignored", tx_word_valid, 0);
    endtask

    // Feed frm[] to the receiver; optional idle cycles between words.
    task automatic rx_frame(input bit gap, input logic [7:0] exp_b, input bit exp_e,
                            input string req);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            rx_word       = frm[i];
            rx_word_valid = 1'b1;
            if (gap && i < 9) begin
                @(negedge clk);
                chk(rx_byte_valid === 1'b0, "R9", "no early byte", rx_byte_valid, 0);
                rx_word_valid = 1'b0;
                rx_word       = 16'h0000;
            end
        end
        @(negedge clk);
        rx_word_valid = 1'b0;
        rx_word       = 16'hFFFF;
        chk(rx_byte_valid === 1'b1, "R5", "byte_valid", rx_byte_valid, 1);
        chk(rx_byte === exp_b, req, "rx_byte", rx_byte, exp_b);
        chk(rx_frame_err === exp_e, "R6", "frame_err", rx_frame_err, exp_e);
        @(negedge clk);
        chk(rx_byte_valid === 1'b0, "R5", "byte_valid pulse", rx_byte_valid, 0);
    endtask

    task automatic build_frame(input logic [7:0] b, input int k,
                               input logic [15:0] stop);
        logic [15:0] m;
        m = 16'((32'd1 << k) - 1);
        frm[0] = m;
        for (int i = 1; i < 9; i++) frm[i] = b[i-1] ? ~m : m;
        frm[9] = stop;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R8 reset state
        chk(tx_ready === 1'b1, "R8", "tx_ready", tx_ready, 1);
        chk(tx_word_valid === 1'b0, "R8", "tx_word_valid", tx_word_valid, 0);
        chk(rx_byte_valid === 1'b0, "R8", "rx_byte_valid", rx_byte_valid, 0);
        chk(sample_tick === 1'b0, "R8", "sample_tick", sample_tick, 0);

        // R4: idle words decoding 1 are discarded
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            rx_word = (i % 2 == 0) ? 16'hFFFF : 16'h0FFF;
            rx_word_valid = 1'b1;
        end
        @(negedge clk);
        rx_word_valid = 1'b0;
        chk(rx_byte_valid === 1'b0, "R4", "idle no byte", rx_byte_valid, 0);
        build_frame(8'hC3, 0, 16'hFFFF);
        rx_frame(1'b0, 8'hC3, 1'b0, "R4");

        // R1/R2/R5/R9: exhaustive loopback
        for (int b = 0; b < 256; b++) begin
            tx_frame(8'(b), (b % 37) == 0);
            for (int i = 0; i < 10; i++) frm[i] = cap[i];
            rx_frame((b % 5) == 0, 8'(b), 1'b0, "R5");
        end

        // R3: noise sweep, k samples disturbed per word
        for (int k = 0; k <= 8; k++) begin
            build_frame(8'h5A, k, 16'hFFFF);
            rx_frame(1'b0, (k < 8) ? 8'h5A : 8'h00, 1'b0, "R3");
        end

        // R6: stop word decoding
        build_frame(8'h81, 0, 16'h0000);
        rx_frame(1'b0, 8'h81, 1'b1, "R6");
        build_frame(8'h7E, 0, 16'h01FF);
        rx_frame(1'b0, 8'h7E, 1'b0, "R6");
        build_frame(8'h3C, 0, 16'h00FF);
        rx_frame(1'b0, 8'h3C, 1'b1, "R6");

        // R7: sample tick spacing
        while (sample_tick !== 1'b1) @(negedge clk);
        for (int r = 0; r < 3; r++) begin
            int n;
            n = 0;
            do begin
                @(negedge clk);
                n++;
                if (n == 1) chk(sample_tick === 1'b0, "R7", "tick width", sample_tick, 0);
            end while (sample_tick !== 1'b1 && n < 1000);
            chk(n == TICK_PER, "R7", "tick period", n, TICK_PER);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule